// File: doc/BRIEF.md
# Load/Store Issue Scheduler with Selectable Ordering Policy

This block holds up to eight memory operations in program order and decides, one per cycle, which of them goes to a single memory port. A front end dispatches a tagged load or store into the tail slot and keeps the returned slot index. Later, one resolve port delivers an operation's effective address, and for a store also its data. Operand readiness is the same thing as address resolution. Stores always write memory in program order from the head of the queue. Loads follow one of three runtime policies. In strict-order mode, only the head may issue. In blind mode, a load issues as soon as its address is known. In conservative mode, a load waits until every older store in the queue has a known address.

When a load issues while an older, resolved store to the same word is still queued, the load takes that store's data on the forwarding outputs and does not read memory. In blind mode a load may issue ahead of an older store whose address is still unknown. When that store later resolves to the load's address, the block raises a squash that names the oldest such load. In the same cycle it discards that load and every younger entry, and it moves the allocation point back to the load's slot. The front end must then dispatch the discarded work again.

Top module: `lsq_sched`

## Requirements
- R1: After synchronous reset the queue is empty, `disp_ready_o` is 1, `disp_idx_o` is 0, and neither `iss_valid_o` nor `sq_valid_o` is asserted.
- R2: Dispatch fills slots 0,1,2,... in order at the tail. With 8 entries held, `disp_ready_o` is 0 and a dispatch request is ignored. Retiring the head entry frees a slot.
- R3: The policy code on `mode_i` is 0 for strict order, 1 for blind, 2 for conservative, and 3 behaves as 0. In strict order, only the head entry may issue, and only once it is resolved.
- R4: In every mode, a store issues only when it is the resolved head entry. It presents its address, its data and `iss_store_o`=1, and it leaves the queue at that clock edge.
- R5: In blind mode, a resolved load issues even while older stores are unresolved or unissued.
- R6: In conservative mode, a load does not issue while any older queued store has an unknown address. Once all of them are known, the load issues.
- R7: A load that issues while an older, resolved, queued store has the same address drives `iss_fwd_o`=1. If several such stores exist, `iss_data_o` carries the data of the youngest one.
- R8: When a store resolves to an address that an already issued younger load used, `sq_valid_o` is 1 in that same cycle and `sq_idx_o` names the oldest such load.
- R9: On a squash, the named load and all younger entries are dropped, and the next `disp_idx_o` equals the squashed slot.
- R10: At most one operation issues per cycle, and the oldest eligible one wins. No operation issues in a cycle in which a queued store resolves.
- R11: A store resolving to a different address from an issued younger load causes no squash. A load whose address matches no older store issues with `iss_fwd_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Issue policy code |
| disp_valid_i | input | 1 | Dispatch request |
| disp_store_i | input | 1 | Dispatched operation is a store |
| disp_ready_o | output | 1 | Slot free and no squash this cycle |
| disp_idx_o | output | 3 | Slot that the next dispatch takes |
| res_valid_i | input | 1 | Address (and store data) delivery |
| res_idx_i | input | 3 | Slot being resolved |
| res_addr_i | input | 32 | Effective address |
| res_data_i | input | 32 | Store data (ignored for loads) |
| iss_valid_o | output | 1 | An operation issues this cycle |
| iss_idx_o | output | 3 | Slot of the issuing operation |
| iss_store_o | output | 1 | Issuing operation is a store |
| iss_addr_o | output | 32 | Address presented to memory |
| iss_data_o | output | 32 | Store data, or forwarded data for a load |
| iss_fwd_o | output | 1 | Load is served by forwarding |
| sq_valid_o | output | 1 | Speculation violation and squash |
| sq_idx_o | output | 3 | Slot of the oldest violating load |

## Verification
The same store-then-load sequence is run under all four policy codes. Only blind mode lets the load go early and then squashes it, while the other codes hold it behind the store. A load placed behind an unresolved head load and three stores, two of which share its address, shows that only the younger matching store's data is forwarded and that strict order stays blocked. An unresolved older store with a different address tells conservative waiting apart from blind issue, and shows that a mismatch does not squash. Two speculative loads to one address check that the squash picks the older load. A fill to eight entries exercises the full condition and the freeing of a slot.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int LQ_DEPTH = 8;
    localparam int LQ_AW    = 32;
    localparam int LQ_DW    = 32;

    typedef enum logic [1:0] {
        POL_INORDER = 2'd0,
        POL_BLIND   = 2'd1,
        POL_CONSERV = 2'd2,
        POL_SPARE   = 2'd3
    } pol_e;

    typedef struct packed {
        logic              valid;
        logic              is_store;
        logic              resolved;
        logic              issued;
        logic [LQ_AW-1:0]  addr;
        logic [LQ_DW-1:0]  data;
    } lsq_ent_t;

    // Two resolved operations touch the same word.
    function automatic logic addr_hit(input logic [LQ_AW-1:0] a,
                                      input logic [LQ_AW-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic [N-1:0]  mask_i,
    input  logic [PW-1:0] head_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);
    logic [PW-1:0] slot;

    // Walk from youngest to oldest so that the oldest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = head_i;
        slot    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            slot = head_i + PW'(k);
            if (mask_i[slot]) begin
                found_o = 1'b1;
                idx_o   = slot;
            end
        end
    end
endmodule

// File: rtl/lsq_fwd_unit.sv
module lsq_fwd_unit
    import lsq_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  lsq_ent_t [N-1:0] ent_i,
    input  logic [PW-1:0]    head_i,
    input  logic [PW-1:0]    ld_idx_i,
    output logic             hit_o,
    output logic [LQ_DW-1:0] data_o
);
    logic [PW-1:0] ld_age;
    logic [PW-1:0] slot;

    // Walk oldest to youngest among entries older than the load; last match is youngest.
    always_comb begin
        ld_age = ld_idx_i - head_i;
        hit_o  = 1'b0;
        data_o = '0;
        slot   = '0;
        for (int k = 0; k < N; k++) begin
            slot = head_i + PW'(k);
            if (PW'(k) < ld_age && ent_i[slot].valid && ent_i[slot].is_store &&
                ent_i[slot].resolved && addr_hit(ent_i[slot].addr, ent_i[ld_idx_i].addr)) begin
                hit_o  = 1'b1;
                data_o = ent_i[slot].data;
            end
        end
    end
endmodule

// File: rtl/lsq_sched.sv
module lsq_sched
    import lsq_pkg::*;
#(
    parameter int DEPTH = LQ_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   mode_i,
    input  logic                         disp_valid_i,
    input  logic                         disp_store_i,
    output logic                         disp_ready_o,
    output logic [$clog2(DEPTH)-1:0]     disp_idx_o,
    input  logic                         res_valid_i,
    input  logic [$clog2(DEPTH)-1:0]     res_idx_i,
    input  logic [LQ_AW-1:0]             res_addr_i,
    input  logic [LQ_DW-1:0]             res_data_i,
    output logic                         iss_valid_o,
    output logic [$clog2(DEPTH)-1:0]     iss_idx_o,
    output logic                         iss_store_o,
    output logic [LQ_AW-1:0]             iss_addr_o,
    output logic [LQ_DW-1:0]             iss_data_o,
    output logic                         iss_fwd_o,
    output logic                         sq_valid_o,
    output logic [$clog2(DEPTH)-1:0]     sq_idx_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    lsq_ent_t [DEPTH-1:0] ent_q;
    logic [PW-1:0]        head_q, tail_q;
    logic [CW-1:0]        cnt_q;

    pol_e                 pol;
    logic                 res_hit, res_store;
    logic [DEPTH-1:0]     blk, cand, cand_m, viol_m;
    logic                 iss_found, sq_found, fwd_hit, pop, do_disp;
    logic [PW-1:0]        iss_idx, sq_idx;
    logic [LQ_DW-1:0]     fwd_data;

    function automatic logic [PW-1:0] age_of(input logic [PW-1:0] idx,
                                             input logic [PW-1:0] head);
        return idx - head;
    endfunction

    assign pol       = pol_e'(mode_i);
    assign res_hit   = res_valid_i && ent_q[res_idx_i].valid;
    assign res_store = res_hit && ent_q[res_idx_i].is_store;

    // Per entry: is some older queued store still without an address?
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blk[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (age_of(PW'(j), head_q) < age_of(PW'(i), head_q) && ent_q[j].valid &&
                    ent_q[j].is_store && !ent_q[j].resolved)
                    blk[i] = 1'b1;
            end
        end
    end

    // Eligibility under the selected policy.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand[i] = ent_q[i].valid && ent_q[i].resolved && !ent_q[i].issued;
            if (ent_q[i].is_store) begin
                cand[i] = cand[i] && (PW'(i) == head_q);
            end else begin
                case (pol)
                    POL_BLIND:   cand[i] = cand[i];
                    POL_CONSERV: cand[i] = cand[i] && !blk[i];
                    default:     cand[i] = cand[i] && (PW'(i) == head_q);
                endcase
            end
        end
    end

    assign cand_m = res_store ? '0 : cand;

    // Issued younger loads that a resolving store invalidates.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            viol_m[i] = res_store && ent_q[i].valid && !ent_q[i].is_store && ent_q[i].issued &&
                        age_of(PW'(i), head_q) > age_of(res_idx_i, head_q) &&
                        addr_hit(ent_q[i].addr, res_addr_i);
        end
    end

    lsq_oldest_pick #(.N(DEPTH), .PW(PW)) u_iss_pick (
        .mask_i (cand_m), .head_i (head_q), .found_o (iss_found), .idx_o (iss_idx)
    );

    lsq_oldest_pick #(.N(DEPTH), .PW(PW)) u_sq_pick (
        .mask_i (viol_m), .head_i (head_q), .found_o (sq_found), .idx_o (sq_idx)
    );

    lsq_fwd_unit #(.N(DEPTH), .PW(PW)) u_fwd (
        .ent_i (ent_q), .head_i (head_q), .ld_idx_i (iss_idx),
        .hit_o (fwd_hit), .data_o (fwd_data)
    );

    assign iss_valid_o  = iss_found;
    assign iss_idx_o    = iss_idx;
    assign iss_store_o  = iss_found && ent_q[iss_idx].is_store;
    assign iss_addr_o   = ent_q[iss_idx].addr;
    assign iss_fwd_o    = iss_found && !ent_q[iss_idx].is_store && fwd_hit;
    assign iss_data_o   = ent_q[iss_idx].is_store ? ent_q[iss_idx].data :
                          (fwd_hit ? fwd_data : '0);
    assign sq_valid_o   = sq_found;
    assign sq_idx_o     = sq_idx;
    assign disp_ready_o = (cnt_q != CW'(DEPTH)) && !sq_found;
    assign disp_idx_o   = tail_q;
    assign do_disp      = disp_valid_i && disp_ready_o;
    assign pop          = ent_q[head_q].valid &&
                          (ent_q[head_q].issued || (iss_found && iss_idx == head_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (res_hit) begin
                ent_q[res_idx_i].addr     <= res_addr_i;
                ent_q[res_idx_i].data     <= res_data_i;
                ent_q[res_idx_i].resolved <= 1'b1;
            end
            if (iss_found)
                ent_q[iss_idx].issued <= 1'b1;
            if (pop) begin
                ent_q[head_q].valid <= 1'b0;
                head_q <= head_q + 1'b1;
            end
            if (sq_found) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (age_of(PW'(i), head_q) >= age_of(sq_idx, head_q))
                        ent_q[i].valid <= 1'b0;
                end
                tail_q <= sq_idx;
                cnt_q  <= {1'b0, age_of(sq_idx, head_q)} - CW'(pop);
            end else begin
                if (do_disp) begin
                    ent_q[tail_q] <= '{valid: 1'b1, is_store: disp_store_i, resolved: 1'b0,
                                       issued: 1'b0, addr: '0, data: '0};
                    tail_q <= tail_q + 1'b1;
                end
                cnt_q <= cnt_q + CW'(do_disp) - CW'(pop);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R2
    AST_STORE_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        iss_valid_o && iss_store_o |-> iss_idx_o == head_q); // R4
    AST_QUIET_ON_STORE_RES: assert property (@(posedge clk) disable iff (rst)
        res_valid_i && ent_q[res_idx_i].valid && ent_q[res_idx_i].is_store |-> !iss_valid_o); // R10
    AST_SQ_NAMES_ISSUED_LOAD: assert property (@(posedge clk) disable iff (rst)
        sq_valid_o |-> ent_q[sq_idx_o].valid && !ent_q[sq_idx_o].is_store && ent_q[sq_idx_o].issued); // R8
    AST_TAIL_AFTER_SQ: assert property (@(posedge clk) disable iff (rst)
        sq_valid_o |=> tail_q == $past(sq_idx_o)); // R9

endmodule

// File: tb/lsq_sched_tb_top.sv
`timescale 1ns/1ps
module lsq_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        disp_valid = 1'b0, disp_store = 1'b0;
    logic        disp_ready;
    logic [2:0]  disp_idx;
    logic        res_valid = 1'b0;
    logic [2:0]  res_idx = '0;
    logic [31:0] res_addr = '0, res_data = '0;
    logic        iss_valid, iss_store, iss_fwd, sq_valid;
    logic [2:0]  iss_idx, sq_idx;
    logic [31:0] iss_addr, iss_data;

    int checks = 0;
    int errors = 0;
    logic        sq_seen;
    logic [2:0]  sq_idx_seen;
    logic        iss_seen;
    logic [2:0]  iss_idx_seen;

    always #10 clk = ~clk;

    lsq_sched dut_i (
        .clk(clk), .rst(rst), .mode_i(mode),
        .disp_valid_i(disp_valid), .disp_store_i(disp_store),
        .disp_ready_o(disp_ready), .disp_idx_o(disp_idx),
        .res_valid_i(res_valid), .res_idx_i(res_idx), .res_addr_i(res_addr), .res_data_i(res_data),
        .iss_valid_o(iss_valid), .iss_idx_o(iss_idx), .iss_store_o(iss_store),
        .iss_addr_o(iss_addr), .iss_data_o(iss_data), .iss_fwd_o(iss_fwd),
        .sq_valid_o(sq_valid), .sq_idx_o(sq_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        disp_valid = 1'b0;
        res_valid = 1'b0;
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    task automatic dispatch(input logic st);
        disp_valid = 1'b1;
        disp_store = st;
        cyc();
        disp_valid = 1'b0;
    endtask

    task automatic resolve(input logic [2:0] idx, input logic [31:0] a, input logic [31:0] d);
        res_valid = 1'b1;
        res_idx   = idx;
        res_addr  = a;
        res_data  = d;
        #1;
        sq_seen      = sq_valid;
        sq_idx_seen  = sq_idx;
        iss_seen     = iss_valid;
        iss_idx_seen = iss_idx;
        cyc();
        res_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        #1;
        chk("R1 ready", {31'd0, disp_ready}, 1);
        chk("R1 tail", {29'd0, disp_idx}, 0);
        chk("R1 no issue", {31'd0, iss_valid}, 0);
        chk("R1 no squash", {31'd0, sq_valid}, 0);

        // Store then load to one address, all four policy codes.
        for (int m = 0; m < 4; m++) begin
            logic blind;
            blind = (m == 1);
            mode = 2'(m);
            do_reset();
            dispatch(1'b1);
            dispatch(1'b0);
            resolve(3'd1, 32'h40, 32'h0);
            #1;
            chk("R5/R3/R6 early load issue", {31'd0, iss_valid}, {31'd0, blind});
            if (blind) begin
                chk("R5 early load idx", {29'd0, iss_idx}, 1);
                chk("R11 no fwd from unresolved", {31'd0, iss_fwd}, 0);
            end
            cyc();
            resolve(3'd0, 32'h40, 32'hAA);
            chk("R8 squash raised", {31'd0, sq_seen}, {31'd0, blind});
            if (blind) chk("R8 squash idx", {29'd0, sq_idx_seen}, 1);
            chk("R10 quiet on store resolve", {31'd0, iss_seen}, 0);
            #1;
            chk("R9 tail after squash", {29'd0, disp_idx}, blind ? 32'd1 : 32'd2);
            chk("R4 head store issues", {31'd0, iss_valid & iss_store}, 1);
            chk("R4 store idx", {29'd0, iss_idx}, 0);
            chk("R4 store addr", iss_addr, 32'h40);
            chk("R4 store data", iss_data, 32'hAA);
            cyc();
            #1;
            chk("R9/R3 load after store", {31'd0, iss_valid}, blind ? 32'd0 : 32'd1);
            if (!blind) begin
                chk("R3 load idx", {29'd0, iss_idx}, 1);
                chk("R11 retired store not forwarded", {31'd0, iss_fwd}, 0);
            end
            cyc();
        end

        // Youngest matching older store forwards.
        for (int m = 0; m < 4; m++) begin
            logic spec;
            spec = (m == 1) || (m == 2);
            mode = 2'(m);
            do_reset();
            for (int k = 0; k < 5; k++) dispatch(k >= 1 && k <= 3);
            resolve(3'd1, 32'h80, 32'h55);
            resolve(3'd2, 32'h80, 32'h66);
            resolve(3'd3, 32'h90, 32'h77);
            resolve(3'd4, 32'h80, 32'h0);
            #1;
            chk("R3/R7 load behind blocked head", {31'd0, iss_valid}, {31'd0, spec});
            if (spec) begin
                chk("R7 fwd idx", {29'd0, iss_idx}, 4);
                chk("R7 fwd flag", {31'd0, iss_fwd}, 1);
                chk("R7 youngest store data", iss_data, 32'h66);
            end
            cyc();
        end

        // Older store with an unknown, later different, address.
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            do_reset();
            dispatch(1'b0);
            dispatch(1'b1);
            dispatch(1'b0);
            resolve(3'd2, 32'h30, 32'h0);
            #1;
            chk("R5/R6 issue past unresolved store", {31'd0, iss_valid}, (m == 1) ? 32'd1 : 32'd0);
            if (m == 1) chk("R5 idx", {29'd0, iss_idx}, 2);
            cyc();
            resolve(3'd1, 32'h34, 32'h99);
            chk("R11 no squash on mismatch", {31'd0, sq_seen}, 0);
            #1;
            chk("R6 load released", {31'd0, iss_valid}, (m == 2) ? 32'd1 : 32'd0);
            if (m == 2) begin
                chk("R6 idx", {29'd0, iss_idx}, 2);
                chk("R11 no fwd on mismatch", {31'd0, iss_fwd}, 0);
            end
            cyc();
        end

        // Two speculative loads, squash names the older.
        mode = 2'd1;
        do_reset();
        dispatch(1'b0);
        dispatch(1'b1);
        dispatch(1'b0);
        dispatch(1'b0);
        resolve(3'd2, 32'h50, 32'h0);
        resolve(3'd3, 32'h50, 32'h0);
        chk("R10 oldest load first", {29'd0, iss_idx_seen}, 2);
        #1;
        chk("R10 next load", {29'd0, iss_idx}, 3);
        cyc();
        resolve(3'd1, 32'h50, 32'h12);
        chk("R8 squash", {31'd0, sq_seen}, 1);
        chk("R8 oldest violator", {29'd0, sq_idx_seen}, 2);
        #1;
        chk("R9 tail reset", {29'd0, disp_idx}, 2);
        chk("R9 ready after squash", {31'd0, disp_ready}, 1);

        // Fill to eight entries.
        mode = 2'd0;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            #1;
            chk("R2 slot order", {29'd0, disp_idx}, 32'(k));
            dispatch(1'b0);
        end
        #1;
        chk("R2 full", {31'd0, disp_ready}, 0);
        dispatch(1'b0);
        #1;
        chk("R2 ignored when full", {31'd0, disp_ready}, 0);
        resolve(3'd0, 32'h4, 32'h0);
        #1;
        chk("R3 head issues", {31'd0, iss_valid}, 1);
        cyc();
        #1;
        chk("R2 slot freed", {31'd0, disp_ready}, 1);
        chk("R2 freed slot idx", {29'd0, disp_idx}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule